// File: doc/BRIEF.md
# External Match Output Controller

This block turns per-channel match strobes from a timer into four output pin levels. Each channel has a two-bit action code that says what a match does to its pin: nothing, force low, force high, or invert. Both the action codes and the present pin levels sit in one control and status word that software reads and writes through a simple write port. The pins are driven straight from the level bits of that word.

A timer core delivers one single-cycle strobe per channel whenever its count equals that channel's match value. A timer that prescales its count still issues only one strobe for each qualifying count. Software can preset the pin levels by writing them. It can also change the actions at any time without disturbing the pins.

Top module: `emo_ctrl`

## Requirements
- R1: After reset the read value is 0, all four pins are low and every action code is 00.
- R2: Pin i always equals bit i of the read value (i = 0..3).
- R3: A write with no match on a channel loads that channel's level from write bit i. The same write loads the action code of channel i from write bits [5+2i:4+2i]. The new values are visible after the write's clock edge.
- R4: In a cycle where channel i's strobe is high, the pin takes its next value after that edge from the action code held before the edge: 00 keeps the level, 01 gives 0, 10 gives 1, 11 inverts it. A strobe held high for several cycles applies the action once per cycle.
- R5: A channel with no strobe and no write keeps its level.
- R6: A strobe on one channel leaves the level of every other channel unchanged.
- R7: When a write and a strobe hit the same channel in the same cycle, the strobe wins for that level bit. It uses the action code and the level held before the edge. The write still loads all action fields and the levels of the other channels.
- R8: Bits 31:12 of the read value read 0 whatever is written to them.
- R9: Changing an action code by a write does not by itself change any pin; only a strobe applies it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| match_evt | input | 4 | Per-channel match strobes, one cycle per qualifying count |
| wr_en | input | 1 | Write strobe for the control and status word |
| wr_data | input | 32 | Write value |
| rd_data | output | 32 | Current control and status word |
| pin_out | output | 4 | External match output levels |

## Verification
The hardest case to reach is a write and a strobe landing on the same channel in the same cycle. Here the old action code must be applied to the old level, while the new codes and the levels of the other channels still take effect. The stimulus reaches it through a full sweep. Every cycle that installs a new code and level pattern also fires a strobe pattern, so all 256 code settings, 16 level patterns and 16 strobe patterns meet in a collision. A second strobe follows each collision to apply the freshly written codes.

// File: rtl/emo_pkg.sv
package emo_pkg;
  localparam int ACT_W = 2;

  typedef enum logic [ACT_W-1:0] {
    ACT_KEEP = 2'b00,
    ACT_LOW  = 2'b01,
    ACT_HIGH = 2'b10,
    ACT_FLIP = 2'b11
  } act_e;

  // Next output level for a channel whose strobe fired.
  function automatic logic apply_act(input logic [ACT_W-1:0] code, input logic lvl);
    case (act_e'(code))
      ACT_KEEP: apply_act = lvl;
      ACT_LOW:  apply_act = 1'b0;
      ACT_HIGH: apply_act = 1'b1;
      default:  apply_act = ~lvl;
    endcase
  endfunction
endpackage

// File: rtl/emo_channel.sv
module emo_channel
  import emo_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             match,
  input  logic             wr_en,
  input  logic             wr_lvl,
  input  logic [ACT_W-1:0] wr_act,
  output logic             lvl,
  output logic [ACT_W-1:0] act,
  output logic             fire
);
  logic lvl_nxt;

  // A strobe on an active (non-keep) code changes the level.
  assign fire = match && (act != ACT_KEEP);

  always_comb begin
    lvl_nxt = lvl;
    if (match)      lvl_nxt = apply_act(act, lvl);
    else if (wr_en) lvl_nxt = wr_lvl;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl <= 1'b0;
      act <= ACT_KEEP;
    end else begin
      lvl <= lvl_nxt;
      if (wr_en) act <= wr_act;
    end
  end
endmodule

// File: rtl/emo_readback.sv
module emo_readback
  import emo_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int DATA_W = 32
) (
  input  logic [NUM_CH-1:0]       lvl,
  input  logic [ACT_W*NUM_CH-1:0] act,
  output logic [DATA_W-1:0]       rd_data
);
  localparam int ACT_LSB = NUM_CH;

  always_comb begin
    rd_data = '0;
    rd_data[NUM_CH-1:0] = lvl;
    rd_data[ACT_LSB +: ACT_W*NUM_CH] = act;
  end
endmodule

// File: rtl/emo_ctrl.sv
module emo_ctrl
  import emo_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] match_evt,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  output logic [NUM_CH-1:0] pin_out
);
  localparam int ACT_LSB = NUM_CH;

  logic [NUM_CH-1:0]       lvl_q;
  logic [ACT_W*NUM_CH-1:0] act_q;
  logic [NUM_CH-1:0]       chan_fire;

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    emo_channel u_ch (
      .clk    (clk),
      .rst_n  (rst_n),
      .match  (match_evt[i]),
      .wr_en  (wr_en),
      .wr_lvl (wr_data[i]),
      .wr_act (wr_data[ACT_LSB + ACT_W*i +: ACT_W]),
      .lvl    (lvl_q[i]),
      .act    (act_q[ACT_W*i +: ACT_W]),
      .fire   (chan_fire[i])
    );
  end

  emo_readback #(.NUM_CH(NUM_CH), .DATA_W(DATA_W)) u_rb (
    .lvl     (lvl_q),
    .act     (act_q),
    .rd_data (rd_data)
  );

  assign pin_out = lvl_q;
endmodule

// File: rtl/emo_ctrl_chk.sv
module emo_ctrl_chk #(
  parameter int NUM_CH = 4,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic [NUM_CH-1:0] match_evt,
  input logic              wr_en,
  input logic [DATA_W-1:0] wr_data,
  input logic [DATA_W-1:0] rd_data,
  input logic [NUM_CH-1:0] pin_out,
  input logic [NUM_CH-1:0] chan_fire
);
  localparam int TOP_USED = 3 * NUM_CH;

  function automatic logic exp_lvl(input logic [1:0] c, input logic l);
    if (c == 2'b11)      exp_lvl = !l;
    else if (c == 2'b00) exp_lvl = l;
    else                 exp_lvl = c[1];
  endfunction

  // R2: pins mirror the level bits of the word
  a_r2_pin_mirror: assert property (@(posedge clk) disable iff (!rst_n)
    pin_out == rd_data[NUM_CH-1:0]);

  // R8: reserved bits read zero
  a_r8_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[DATA_W-1:TOP_USED] == '0);

  for (genvar i = 0; i < NUM_CH; i++) begin : g_a
    // R4 and R7: a strobe applies the pre-edge code to the pre-edge level
    a_r4_action: assert property (@(posedge clk) disable iff (!rst_n)
      $past(match_evt[i]) |->
        pin_out[i] == exp_lvl($past(rd_data[NUM_CH+2*i +: 2]), $past(pin_out[i])));
    // R3: write without strobe loads the level
    a_r3_load: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(wr_en) && !$past(match_evt[i])) |-> pin_out[i] == $past(wr_data[i]));
    // R5: nothing happening keeps the level
    a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!$past(wr_en) && !$past(match_evt[i])) |-> pin_out[i] == $past(pin_out[i]));
    // R4: a changing strobe only comes from a fire event
    a_r4_fire_only: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(match_evt[i]) && !$past(chan_fire[i])) |-> $stable(pin_out[i]));
  end
endmodule

bind emo_ctrl emo_ctrl_chk #(.NUM_CH(NUM_CH), .DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .match_evt (match_evt),
  .wr_en     (wr_en),
  .wr_data   (wr_data),
  .rd_data   (rd_data),
  .pin_out   (pin_out),
  .chan_fire (chan_fire)
);

// File: tb/emo_ctrl_test.sv
module emo_ctrl_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  match_evt = '0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic [3:0]  pin_out;

  int n_cmp = 0;
  int n_bad = 0;
  logic [3:0] m_lvl;
  logic [7:0] m_act;
  bit finished = 0;

  always #4 clk = ~clk;

  emo_ctrl uut (
    .clk(clk), .rst_n(rst_n), .match_evt(match_evt),
    .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data), .pin_out(pin_out)
  );

  function automatic logic nxt(input int code, input logic l);
    if (code == 0)      return l;
    else if (code == 3) return l ^ 1'b1;
    else                return logic'(code - 1);
  endfunction

  task automatic check(input string req);
    logic [31:0] exp;
    exp = {20'b0, m_act, m_lvl};
    n_cmp++;
    if (rd_data !== exp || pin_out !== m_lvl) begin
      n_bad++;
      $display("FAIL %s: rd_data=%h pin_out=%b expected rd_data=%h pin_out=%b",
               req, rd_data, pin_out, exp, m_lvl);
    end
  endtask

  // Drive at negedge, clock, update model, sample at next negedge.
  task automatic step(input logic [3:0] m, input logic w, input logic [31:0] d, input string req);
    logic [3:0] nl;
    match_evt = m; wr_en = w; wr_data = d;
    for (int i = 0; i < 4; i++)
      nl[i] = m[i] ? nxt(int'(m_act[2*i +: 2]), m_lvl[i]) : (w ? d[i] : m_lvl[i]);
    @(negedge clk);
    m_lvl = nl;
    if (w) m_act = d[11:4];
    match_evt = '0; wr_en = 1'b0; wr_data = '0;
    check(req);
  endtask

  initial begin
    m_lvl = '0; m_act = '0;
    repeat (3) @(negedge clk);
    check("R1");
    rst_n = 1'b1;
    @(negedge clk);
    check("R1");
    // R8: reserved bits ignore writes
    step(4'h0, 1'b1, 32'hFFFF_F000, "R8");
    step(4'h0, 1'b1, 32'hFFFF_FFFF, "R8");
    // R9: codes alone don't move pins; R5 idle hold
    step(4'h0, 1'b1, 32'h0000_0FF5, "R9");
    step(4'h0, 1'b0, 32'h0, "R5");
    // R4: held strobe toggles every cycle
    step(4'h0, 1'b1, 32'h0000_00F0, "R3");
    step(4'h1, 1'b0, 32'h0, "R4");
    step(4'h1, 1'b0, 32'h0, "R4");
    step(4'h1, 1'b0, 32'h0, "R4");
    // R6: single channel set, others untouched
    step(4'h0, 1'b1, 32'h0000_0AA5, "R3");
    step(4'h2, 1'b0, 32'h0, "R6");
    step(4'h8, 1'b0, 32'h0, "R6");
    // R7 and R4 sweep: collision cycle then strobe with new codes
    for (int a = 0; a < 256; a++)
      for (int l = 0; l < 16; l++)
        for (int m = 0; m < 16; m++) begin
          step(4'(m), 1'b1, {20'b0, 8'(a), 4'(l)}, "R7");
          step(4'(m ^ l), 1'b0, 32'h0, "R4");
        end
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (195000) @(posedge clk);
    if (!finished) begin
      n_bad++;
      n_cmp++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule